// File: doc/BRIEF.md
# Exception Entry Sequencer with Mode-Banked Registers

This block performs the state changes a processor makes when it takes an exception. It accepts a request carrying one of four exception kinds: privileged call, instruction-fetch trap, data-access trap or interrupt. From the kind it picks the mode to enter and a vector offset. A high-vector control input can move the offset to the top of the address space. The block holds the architectural copies of general registers 29 and 30, the saved-status register and the status register. Behind these sits one bank of saved copies for each register group.

When an exception moves the processor into a mode that uses a different bank, the live registers are parked in the old mode's bank and register 29 is refilled from the new one. Register 30 then takes the interrupted program counter. The saved-status register takes the whole prior status. The status gets the new mode and has its interrupt-disable bit set, and the vector address appears on the PC output together with a one-cycle done pulse. A write port lets the core's datapath update the four registers. A status write that changes the mode swaps banks in the same way, so the datapath can steer the processor between modes.

Top module: `xe_exc_entry`

## Requirements
- R1: After reset the status reads 0x00000082 (mode code 2 in bits [2:0], interrupt-disable bit 7 set). Registers 29 and 30, the saved status and the PC output read zero, and done and error are low.
- R2: With the high-vector input low, the PC output becomes 0x08 for kind 0 (privileged), 0x0C for kind 1 (instruction trap), 0x10 for kind 2 (data trap) and 0x18 for kind 3 (interrupt).
- R3: With the high-vector input high, 0xFFFF0000 is added to the offset of R2.
- R4: Mode codes in status bits [2:0] are: user 0, system 1, privileged 2, trap 3, extension 4, interrupt 5. Kind 0 enters mode 2, kinds 1 and 2 enter mode 3, and kind 3 enters mode 5. On entry only bits [2:0] and bit 7 of the status change, and bit 7 becomes 1.
- R5: On entry the saved-status register takes the full status held before the entry, register 30 takes the PC input, and the PC output takes the vector address.
- R6: When an entry changes the bank, the old mode's bank receives registers 29 and 30 and the saved status, and register 29 is reloaded from the new mode's bank.
- R7: An entry whose new mode equals the current mode swaps nothing: register 29 and all bank contents are unchanged.
- R8: Banks: modes 0 and 1 share bank 0, and mode codes 6 and 7 also use bank 0. Mode 2 uses bank 1, mode 3 bank 2, mode 4 bank 3 and mode 5 bank 4. A mode change between two modes of one bank leaves all three registers unchanged.
- R9: The write port selects register 29 (0), register 30 (1), saved status (2) or status (3). A status write whose mode field maps to a different bank first parks the three registers in the old bank, then reloads all three from the new bank.
- R10: A request with a kind code of 4 to 7 pulses the error output for one cycle and changes no register, no bank and no output other than the error output.
- R11: The done output is high for exactly the one cycle after the request is sampled, and the entry's register updates are visible in that same cycle.
- R12: When a request and a write arrive in the same cycle, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Exception request, sampled on the rising edge |
| exc_type_i | input | 3 | Exception kind code |
| pc_i | input | DW | Program counter of the interrupted instruction |
| hivec_i | input | 1 | Relocate vectors to the high base |
| wr_en_i | input | 1 | Register write enable from the datapath |
| wr_sel_i | input | 2 | Register selected for writing |
| wr_data_i | input | DW | Write data |
| status_o | output | DW | Current status register |
| r29_o | output | DW | Live register 29 |
| r30_o | output | DW | Live register 30 |
| bsr_o | output | DW | Live saved-status register |
| new_pc_o | output | DW | Vector address of the last entry |
| done_o | output | 1 | Entry completed (one-cycle pulse) |
| err_o | output | 1 | Unknown exception kind (one-cycle pulse) |

## Verification
The hardest state to reach from the ports is a bank being read back after it was parked. Exceptions only ever enter three modes, so a value reaches a bank and comes back only when the processor leaves a mode and later returns to it. The stimulus uses status writes to drive the processor into the user, system, extension and unused mode codes. It takes exceptions out of those modes and re-enters them later, so that every bank, the shared bank 0 and the codes 6 and 7 each show their parked contents on register 29, register 30 and the saved status.

// File: rtl/xe_pkg.sv
package xe_pkg;

  localparam int XE_MW    = 3;
  localparam int XE_NBANK = 5;
  localparam int XE_BW    = $clog2(XE_NBANK);

  typedef logic [XE_MW-1:0] xe_mode_t;

  // Mode codes held in the low status bits
  localparam xe_mode_t XE_M_USR = 3'd0;
  localparam xe_mode_t XE_M_SYS = 3'd1;
  localparam xe_mode_t XE_M_PRV = 3'd2;
  localparam xe_mode_t XE_M_TRP = 3'd3;
  localparam xe_mode_t XE_M_EXT = 3'd4;
  localparam xe_mode_t XE_M_IRQ = 3'd5;

  // Exception kind codes
  localparam logic [2:0] XE_X_PRIV  = 3'd0;
  localparam logic [2:0] XE_X_ITRAP = 3'd1;
  localparam logic [2:0] XE_X_DTRAP = 3'd2;
  localparam logic [2:0] XE_X_INTR  = 3'd3;

  // Write-port register selectors
  localparam logic [1:0] XE_W_R29  = 2'd0;
  localparam logic [1:0] XE_W_R30  = 2'd1;
  localparam logic [1:0] XE_W_BSR  = 2'd2;
  localparam logic [1:0] XE_W_STAT = 2'd3;

endpackage

// File: rtl/xe_vector_map.sv
module xe_vector_map
  import xe_pkg::*;
#(
  parameter int              DW         = 32,
  parameter logic [DW-1:0]   HIVEC_BASE = 'hFFFF_0000
) (
  input  logic [2:0]    kind_i,
  input  logic          hivec_i,
  output logic          valid_o,
  output xe_mode_t      mode_o,
  output logic [DW-1:0] vec_o
);

  localparam int OFFW = 5;

  logic [OFFW-1:0] offset;

  always_comb begin
    valid_o = 1'b1;
    mode_o  = XE_M_PRV;
    offset  = '0;
    case (kind_i)
      XE_X_PRIV:  begin mode_o = XE_M_PRV; offset = 5'h08; end
      XE_X_ITRAP: begin mode_o = XE_M_TRP; offset = 5'h0C; end
      XE_X_DTRAP: begin mode_o = XE_M_TRP; offset = 5'h10; end
      XE_X_INTR:  begin mode_o = XE_M_IRQ; offset = 5'h18; end
      default:    begin valid_o = 1'b0; mode_o = XE_M_USR; offset = '0; end
    endcase
  end

  assign vec_o = DW'(offset) + (hivec_i ? HIVEC_BASE : '0);

endmodule

// File: rtl/xe_bank_map.sv
module xe_bank_map
  import xe_pkg::*;
(
  input  xe_mode_t         mode_i,
  output logic [XE_BW-1:0] bank_o
);

  always_comb begin
    case (mode_i)
      XE_M_PRV: bank_o = XE_BW'(1);
      XE_M_TRP: bank_o = XE_BW'(2);
      XE_M_EXT: bank_o = XE_BW'(3);
      XE_M_IRQ: bank_o = XE_BW'(4);
      default:  bank_o = XE_BW'(0);  // user, system and unused codes
    endcase
  end

endmodule

// File: rtl/xe_bank_file.sv
module xe_bank_file
  import xe_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NBANK = XE_NBANK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_en_i,
  input  logic [XE_BW-1:0] st_idx_i,
  input  logic [DW-1:0]    st_r29_i,
  input  logic [DW-1:0]    st_r30_i,
  input  logic [DW-1:0]    st_bsr_i,
  input  logic [XE_BW-1:0] ld_idx_i,
  output logic [DW-1:0]    ld_r29_o,
  output logic [DW-1:0]    ld_r30_o,
  output logic [DW-1:0]    ld_bsr_o
);

  logic [DW-1:0] b29 [NBANK];
  logic [DW-1:0] b30 [NBANK];
  logic [DW-1:0] bsr [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = st_en_i && (st_idx_i == XE_BW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b29[g] <= '0;
        b30[g] <= '0;
        bsr[g] <= '0;
      end else if (hit) begin
        b29[g] <= st_r29_i;
        b30[g] <= st_r30_i;
        bsr[g] <= st_bsr_i;
      end
    end
  end

  always_comb begin
    ld_r29_o = '0;
    ld_r30_o = '0;
    ld_bsr_o = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (ld_idx_i == XE_BW'(i)) begin
        ld_r29_o = b29[i];
        ld_r30_o = b30[i];
        ld_bsr_o = bsr[i];
      end
    end
  end

  AST_BANK_INDEX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st_en_i |-> (st_idx_i < XE_BW'(NBANK)) && (ld_idx_i < XE_BW'(NBANK))) else $error("bank index"); // R8

endmodule

// File: rtl/xe_exc_entry.sv
module xe_exc_entry
  import xe_pkg::*;
#(
  parameter int            DW         = 32,
  parameter int            IBIT       = 7,
  parameter logic [DW-1:0] HIVEC_BASE = 'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req_i,
  input  logic [2:0]    exc_type_i,
  input  logic [DW-1:0] pc_i,
  input  logic          hivec_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] r29_o,
  output logic [DW-1:0] r30_o,
  output logic [DW-1:0] bsr_o,
  output logic [DW-1:0] new_pc_o,
  output logic          done_o,
  output logic          err_o
);

  localparam logic [DW-1:0] ST_RESET = (DW'(1) << IBIT) | DW'(XE_M_PRV);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // Architectural state
  logic [DW-1:0] r29_q, r30_q, bsr_q, status_q, pc_q;
  logic          done_q, err_q;

  // Decode
  xe_mode_t         old_mode, exc_mode, tgt_mode;
  logic             vec_ok;
  logic [DW-1:0]    vec_addr;
  logic [XE_BW-1:0] old_bank, new_bank;
  logic             accept, bad, wr_go, st_wr, swap;
  logic [DW-1:0]    ld_r29, ld_r30, ld_bsr;

  assign old_mode = status_q[XE_MW-1:0];

  xe_vector_map #(.DW(DW), .HIVEC_BASE(HIVEC_BASE)) u_vec (
    .kind_i  (exc_type_i),
    .hivec_i (hivec_i),
    .valid_o (vec_ok),
    .mode_o  (exc_mode),
    .vec_o   (vec_addr)
  );

  always_comb begin
    accept   = exc_req_i & vec_ok;
    bad      = exc_req_i & ~vec_ok;
    wr_go    = wr_en_i & ~exc_req_i;
    st_wr    = wr_go && (wr_sel_i == XE_W_STAT);
    tgt_mode = accept ? exc_mode : wr_data_i[XE_MW-1:0];
  end

  xe_bank_map u_map_old (.mode_i(old_mode), .bank_o(old_bank));
  xe_bank_map u_map_new (.mode_i(tgt_mode), .bank_o(new_bank));

  assign swap = (accept | st_wr) && (old_bank != new_bank);

  xe_bank_file #(.DW(DW), .NBANK(XE_NBANK)) u_banks (
    .clk      (clk),
    .rst_n    (rst_q),
    .st_en_i  (swap),
    .st_idx_i (old_bank),
    .st_r29_i (r29_q),
    .st_r30_i (r30_q),
    .st_bsr_i (bsr_q),
    .ld_idx_i (new_bank),
    .ld_r29_o (ld_r29),
    .ld_r30_o (ld_r30),
    .ld_bsr_o (ld_bsr)
  );

  // Next-state logic with explicit clock enables
  logic          r29_en, r30_en, bsr_en, st_en, pc_en;
  logic [DW-1:0] r29_d, r30_d, bsr_d, st_d, pc_d;

  always_comb begin
    r29_en = 1'b0; r29_d = r29_q;
    if (swap) begin
      r29_en = 1'b1; r29_d = ld_r29;
    end else if (wr_go && (wr_sel_i == XE_W_R29)) begin
      r29_en = 1'b1; r29_d = wr_data_i;
    end

    r30_en = 1'b0; r30_d = r30_q;
    if (accept) begin
      r30_en = 1'b1; r30_d = pc_i;
    end else if (swap) begin
      r30_en = 1'b1; r30_d = ld_r30;
    end else if (wr_go && (wr_sel_i == XE_W_R30)) begin
      r30_en = 1'b1; r30_d = wr_data_i;
    end

    bsr_en = 1'b0; bsr_d = bsr_q;
    if (accept) begin
      bsr_en = 1'b1; bsr_d = status_q;
    end else if (swap) begin
      bsr_en = 1'b1; bsr_d = ld_bsr;
    end else if (wr_go && (wr_sel_i == XE_W_BSR)) begin
      bsr_en = 1'b1; bsr_d = wr_data_i;
    end

    st_en = 1'b0; st_d = status_q;
    if (accept) begin
      st_en             = 1'b1;
      st_d[XE_MW-1:0]   = exc_mode;
      st_d[IBIT]        = 1'b1;
    end else if (st_wr) begin
      st_en = 1'b1; st_d = wr_data_i;
    end

    pc_en = accept;
    pc_d  = vec_addr;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      r29_q <= '0;
    end else if (r29_en) begin
      r29_q <= r29_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      r30_q <= '0;
    end else if (r30_en) begin
      r30_q <= r30_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bsr_q <= '0;
    end else if (bsr_en) begin
      bsr_q <= bsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      status_q <= ST_RESET;
    end else if (st_en) begin
      status_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= accept;
      err_q  <= bad;
    end
  end

  assign status_o = status_q;
  assign r29_o    = r29_q;
  assign r30_o    = r30_q;
  assign bsr_o    = bsr_q;
  assign new_pc_o = pc_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // Checks next to the logic they guard
  AST_R30_TAKES_PC: assert property (@(posedge clk) disable iff (!rst_q)
    accept |=> r30_q == $past(pc_i)) else $error("r30 after entry"); // R5

  AST_BSR_TAKES_STATUS: assert property (@(posedge clk) disable iff (!rst_q)
    accept |=> bsr_q == $past(status_q)) else $error("bsr after entry"); // R5

  AST_IBIT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> status_q[IBIT]) else $error("interrupt-disable bit"); // R4

  AST_SAME_MODE_KEEPS_R29: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && (exc_mode == old_mode)) |=> r29_q == $past(r29_q)) else $error("same-mode swap"); // R7

  AST_BAD_KIND_HOLDS: assert property (@(posedge clk) disable iff (!rst_q)
    bad |=> $stable(status_q) && $stable(pc_q) && $stable(r29_q) && $stable(r30_q) && $stable(bsr_q))
    else $error("state moved on bad kind"); // R10

  AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_q)
    !(done_q && err_q)) else $error("done with error"); // R10

  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> $past(exc_req_i)) else $error("done without request"); // R11

  AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> (pc_q[1:0] == 2'b00)) else $error("vector alignment"); // R2

endmodule

// File: tb/xe_exc_entry_test.sv
module xe_exc_entry_test;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          exc_req_i;
  logic [2:0]    exc_type_i;
  logic [DW-1:0] pc_i;
  logic          hivec_i;
  logic          wr_en_i;
  logic [1:0]    wr_sel_i;
  logic [DW-1:0] wr_data_i;
  logic [DW-1:0] status_o, r29_o, r30_o, bsr_o, new_pc_o;
  logic          done_o, err_o;

  always #5 clk = ~clk;

  xe_exc_entry uut (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .exc_type_i(exc_type_i),
    .pc_i(pc_i), .hivec_i(hivec_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .status_o(status_o), .r29_o(r29_o), .r30_o(r30_o),
    .bsr_o(bsr_o), .new_pc_o(new_pc_o), .done_o(done_o), .err_o(err_o)
  );

  typedef struct {
    logic [DW-1:0] r29, r30, bsr, st, pc;
    logic          done, err;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  // Reference state built from the requirements
  logic [DW-1:0] m_r29, m_r30, m_bsr, m_st, m_pc;
  logic [DW-1:0] k29 [5];
  logic [DW-1:0] k30 [5];
  logic [DW-1:0] kbs [5];

  function automatic int bank_of(input logic [2:0] m);
    case (m)
      3'd2: return 1;
      3'd3: return 2;
      3'd4: return 3;
      3'd5: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit req, input logic [2:0] kind, input logic [DW-1:0] pc,
                      input bit hv, input bit we, input logic [1:0] sel,
                      input logic [DW-1:0] wd, input string tag);
    exp_t e;
    bit   acc, bad;
    int   ob, nb;
    logic [2:0] nm;
    @(negedge clk);
    exc_req_i = req; exc_type_i = kind; pc_i = pc; hivec_i = hv;
    wr_en_i = we; wr_sel_i = sel; wr_data_i = wd;
    acc = req && (kind < 3'd4);
    bad = req && (kind >= 3'd4);
    ob  = bank_of(m_st[2:0]);
    if (acc) begin
      nm = (kind == 3'd0) ? 3'd2 : (kind == 3'd3) ? 3'd5 : 3'd3;
      nb = bank_of(nm);
      if (nb != ob) begin
        k29[ob] = m_r29; k30[ob] = m_r30; kbs[ob] = m_bsr;
        m_r29 = k29[nb];
      end
      m_r30 = pc;
      m_bsr = m_st;
      m_st  = (m_st & ~32'h7) | DW'(nm) | 32'h80;
      case (kind)
        3'd0: m_pc = 32'h08;
        3'd1: m_pc = 32'h0C;
        3'd2: m_pc = 32'h10;
        default: m_pc = 32'h18;
      endcase
      if (hv) m_pc = m_pc + 32'hFFFF_0000;
    end else if (we && !req) begin
      case (sel)
        2'd0: m_r29 = wd;
        2'd1: m_r30 = wd;
        2'd2: m_bsr = wd;
        default: begin
          nb = bank_of(wd[2:0]);
          if (nb != ob) begin
            k29[ob] = m_r29; k30[ob] = m_r30; kbs[ob] = m_bsr;
            m_r29 = k29[nb]; m_r30 = k30[nb]; m_bsr = kbs[nb];
          end
          m_st = wd;
        end
      endcase
    end
    e.r29 = m_r29; e.r30 = m_r30; e.bsr = m_bsr; e.st = m_st; e.pc = m_pc;
    e.done = acc; e.err = bad; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exc(input logic [2:0] kind, input logic [DW-1:0] pc, input bit hv, input string tag);
    step(1'b1, kind, pc, hv, 1'b0, 2'd0, '0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] wd, input string tag);
    step(1'b0, 3'd0, '0, 1'b0, 1'b1, sel, wd, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 3'd0, '0, 1'b0, 1'b0, 2'd0, '0, tag);
  endtask

  // Monitor: compares each cycle's result after the edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (r29_o !== e.r29 || r30_o !== e.r30 || bsr_o !== e.bsr || status_o !== e.st ||
            new_pc_o !== e.pc || done_o !== e.done || err_o !== e.err) begin
          errors++;
          $display("FAIL %s: act r29=%h r30=%h bsr=%h st=%h pc=%h done=%b err=%b exp r29=%h r30=%h bsr=%h st=%h pc=%h done=%b err=%b",
                   e.tag, r29_o, r30_o, bsr_o, status_o, new_pc_o, done_o, err_o,
                   e.r29, e.r30, e.bsr, e.st, e.pc, e.done, e.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    exc_req_i = 0; exc_type_i = 0; pc_i = 0; hivec_i = 0;
    wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0;
    m_r29 = 0; m_r30 = 0; m_bsr = 0; m_st = 32'h82; m_pc = 0;
    for (int i = 0; i < 5; i++) begin k29[i] = 0; k30[i] = 0; kbs[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    checks++;
    if (status_o !== 32'h82 || r29_o !== 0 || r30_o !== 0 || bsr_o !== 0 ||
        new_pc_o !== 0 || done_o !== 0 || err_o !== 0) begin
      errors++;
      $display("FAIL R1: act st=%h r29=%h r30=%h bsr=%h pc=%h done=%b err=%b exp st=00000082 zeros",
               status_o, r29_o, r30_o, bsr_o, new_pc_o, done_o, err_o);
    end

    wr(2'd0, 32'h0000_029A, "R9 write r29");
    wr(2'd1, 32'h0000_030A, "R9 write r30");
    wr(2'd2, 32'h0000_0B5A, "R9 write bsr");
    exc(3'd0, 32'h1000, 1'b0, "R7 R2 privileged from privileged");
    idle("R11 done drops");
    exc(3'd3, 32'h2000, 1'b0, "R6 R2 interrupt entry swaps bank");
    wr(2'd0, 32'h0000_4444, "R9 r29 in interrupt mode");
    exc(3'd1, 32'h3000, 1'b1, "R3 R4 instruction trap high vector");
    exc(3'd2, 32'h3004, 1'b1, "R3 R7 data trap same mode");
    exc(3'd0, 32'h4000, 1'b0, "R6 back to privileged restores r29");
    exc(3'd3, 32'h4100, 1'b0, "R6 back to interrupt restores r29");
    step(1'b1, 3'd5, 32'h5000, 1'b0, 1'b1, 2'd0, 32'hDEAD, "R10 R12 bad kind");
    idle("R10 error drops");
    step(1'b1, 3'd1, 32'h5100, 1'b0, 1'b1, 2'd0, 32'hBEEF, "R12 write dropped on entry");
    wr(2'd3, 32'h5A00_0000, "R9 status write to user");
    wr(2'd0, 32'h0000_1111, "R9 r29 in user");
    wr(2'd1, 32'h0000_1112, "R9 r30 in user");
    wr(2'd3, 32'h5A00_0001, "R8 user to system shares bank");
    exc(3'd2, 32'h6000, 1'b0, "R4 data trap keeps other status bits");
    wr(2'd3, 32'h0000_0004, "R8 R9 enter extension");
    wr(2'd0, 32'h0000_3333, "R9 r29 in extension");
    exc(3'd0, 32'h7000, 1'b0, "R6 extension parked");
    wr(2'd3, 32'h0000_0084, "R8 extension restored");
    wr(2'd3, 32'h0000_0006, "R8 code 6 uses bank 0");
    wr(2'd3, 32'h0000_0007, "R8 code 7 same bank");
    for (int k = 0; k < 4; k++) begin
      exc(3'(k), 32'h8000 + DW'(k), 1'b0, "R2 R4 kind sweep low");
      exc(3'(k), 32'h9000 + DW'(k), 1'b1, "R3 R4 kind sweep high");
    end
    exc(3'd7, 32'hA000, 1'b1, "R10 kind 7");
    idle("R11 quiet");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule